// File: doc/BRIEF.md
# Aligned dual-ratio clock divider

The block takes one fast input clock and derives two slower square waves from the same rising edges. The first output runs at half the input rate. The second runs at one quarter or one sixth of the input rate, as chosen by a select input. Both outputs come out of registers clocked by the same edge, so every rising edge the two waves share falls on the same input edge. A phase marker goes high for one input cycle on each of those shared rising edges. Other logic can use it to line up with the divided clocks.

A common enable works as a clock-enable, not as a gated clock. It is captured on the falling edge of the input clock, so a change can only take effect while the input clock is low. While the block is disabled, both divided outputs and the internal counters hold their state. The asynchronous master reset puts every stage into a known state. Because of this, several instances released by the same reset produce identical waveforms.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While `mr_i` is 1, `half_o`, `ratio_o` and `mark_o` are 0, and they stay 0 until the first enabled rising edge after release. Each output is forced low as soon as `mr_i` rises, without waiting for a clock edge.
- R2: On every enabled rising edge of `clk_i`, `half_o` inverts, so it is high for one enabled cycle and low for one.
- R3: With `ratio_sel_i` = 0, `ratio_o` repeats a pattern of 2 enabled cycles high followed by 2 low.
- R4: With `ratio_sel_i` = 1, `ratio_o` repeats a pattern of 3 enabled cycles high followed by 3 low.
- R5: Every rising edge of `ratio_o` happens on the same clock edge as a rising edge of `half_o`. The first enabled edge after reset raises both outputs.
- R6: `mark_o` is 1 for exactly the one cycle that follows an edge on which `half_o` and `ratio_o` both rose, and 0 in every other cycle.
- R7: `en_i` is sampled on the falling edge of `clk_i`. A value present at a falling edge governs the next rising edge, and a change made after a falling edge has no effect until the falling edge after it.
- R8: On a rising edge with the captured enable at 0, `half_o` and `ratio_o` keep their values, `mark_o` is 0, and the position in the period is frozen. Counting resumes from that position when the enable returns.
- R9: `ratio_sel_i` is only taken in at the start of a slow-output period, when the counter is at zero. A period that has already begun always finishes with its old length.
- R10: A reset asserted in the middle of a run clears all outputs at once. The pattern then starts over from its reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| mr_i | input | 1 | Master reset, asynchronous, active high |
| en_i | input | 1 | Common enable, captured on the falling clock edge |
| ratio_sel_i | input | 1 | 0 selects divide by 4, 1 selects divide by 6 |
| half_o | output | 1 | Divide-by-2 output |
| ratio_o | output | 1 | Divide-by-4/6 output |
| mark_o | output | 1 | One-cycle pulse on shared rising edges |

## Verification
The properties assume that `en_i` and `ratio_sel_i` are steady around the clock edges that sample them. They also assume that `mr_i` is asserted from time zero, so that no check sees the power-up state. The bench changes its inputs one time unit after a rising edge in the normal case. For the late-enable case it changes them two units after a falling edge, which still keeps them away from both sampling edges. It holds the master reset high from the first instant and releases it away from any edge.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic {
        RATIO_LO = 1'b0,
        RATIO_HI = 1'b1
    } ratio_e;

    typedef struct packed {
        logic wave;
    } half_state_t;

    typedef struct packed {
        logic mark;
    } mark_state_t;

endpackage

// File: rtl/cdiv_gate_capture.sv
module cdiv_gate_capture (
    input  logic clk_i,
    input  logic mr_i,
    input  logic en_i,
    output logic en_o
);

    logic en_q;

    always_ff @(negedge clk_i or posedge mr_i) begin
        if (mr_i) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/cdiv_half.sv
module cdiv_half
    import cdiv_pkg::*;
(
    input  logic clk_i,
    input  logic mr_i,
    input  logic step_i,
    output logic wave_o,
    output logic rise_o
);

    half_state_t st_d;
    half_state_t st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        if (step_i) begin
            st_d.wave = ~st_q.wave;
            rise_o    = ~st_q.wave;
        end
    end

    always_ff @(posedge clk_i or posedge mr_i) begin
        if (mr_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = st_q.wave;

endmodule

// File: rtl/cdiv_ratio.sv
module cdiv_ratio
    import cdiv_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk_i,
    input  logic mr_i,
    input  logic step_i,
    input  logic sel_i,
    output logic wave_o,
    output logic rise_o
);

    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW      = $clog2(DIV_MAX);
    localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI - 1);
    localparam logic [CW-1:0] HALF_LO = CW'(DIV_LO / 2);
    localparam logic [CW-1:0] HALF_HI = CW'(DIV_HI / 2);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        ratio_e        mode;
        logic          wave;
    } ratio_state_t;

    ratio_state_t st_d;
    ratio_state_t st_q;
    ratio_e       mode_eff;
    logic [CW-1:0] last_eff;
    logic [CW-1:0] half_eff;

    always_comb begin
        if (st_q.cnt == '0) begin
            mode_eff = sel_i ? RATIO_HI : RATIO_LO;
        end else begin
            mode_eff = st_q.mode;
        end
        last_eff = (mode_eff == RATIO_HI) ? LAST_HI : LAST_LO;
        half_eff = (mode_eff == RATIO_HI) ? HALF_HI : HALF_LO;
    end

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        if (step_i) begin
            st_d.mode = mode_eff;
            if (st_q.cnt == last_eff) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
            st_d.wave = (st_d.cnt >= ONE) && (st_d.cnt <= half_eff);
            rise_o    = (st_d.cnt == ONE);
        end
    end

    always_ff @(posedge clk_i or posedge mr_i) begin
        if (mr_i) begin
            st_q <= '{cnt: '0, mode: RATIO_LO, wave: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = st_q.wave;

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
    import cdiv_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6
) (
    input  logic clk_i,
    input  logic mr_i,
    input  logic en_i,
    input  logic ratio_sel_i,
    output logic half_o,
    output logic ratio_o,
    output logic mark_o
);

    logic        en_q;
    logic        half_rise;
    logic        ratio_rise;
    mark_state_t mk_d;
    mark_state_t mk_q;

    cdiv_gate_capture u_gate (
        .clk_i (clk_i),
        .mr_i  (mr_i),
        .en_i  (en_i),
        .en_o  (en_q)
    );

    cdiv_half u_half (
        .clk_i  (clk_i),
        .mr_i   (mr_i),
        .step_i (en_q),
        .wave_o (half_o),
        .rise_o (half_rise)
    );

    cdiv_ratio #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_ratio (
        .clk_i  (clk_i),
        .mr_i   (mr_i),
        .step_i (en_q),
        .sel_i  (ratio_sel_i),
        .wave_o (ratio_o),
        .rise_o (ratio_rise)
    );

    always_comb begin
        mk_d.mark = half_rise && ratio_rise;
    end

    always_ff @(posedge clk_i or posedge mr_i) begin
        if (mr_i) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mark_o = mk_q.mark;

endmodule

// File: rtl/dual_ratio_clkdiv_chk.sv
module dual_ratio_clkdiv_chk (
    input logic clk_i,
    input logic mr_i,
    input logic en_q,
    input logic half_o,
    input logic ratio_o,
    input logic mark_o
);

    always @(negedge clk_i) begin
        if (mr_i) begin
            a_reset_low_r1: assert (!half_o && !ratio_o && !mark_o)
                else $error("outputs not low in reset");
        end
    end

    p_half_toggle_r2: assert property (@(posedge clk_i) disable iff (mr_i)
        en_q |=> (half_o != $past(half_o)));

    p_rise_shared_r5: assert property (@(posedge clk_i) disable iff (mr_i)
        $rose(ratio_o) |-> $rose(half_o));

    p_mark_on_high_r6: assert property (@(posedge clk_i) disable iff (mr_i)
        mark_o |-> (half_o && ratio_o));

    p_mark_single_r6: assert property (@(posedge clk_i) disable iff (mr_i)
        mark_o |=> !mark_o);

    p_freeze_r8: assert property (@(posedge clk_i) disable iff (mr_i)
        !en_q |=> ($stable(half_o) && $stable(ratio_o) && !mark_o));

endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk u_chk (
    .clk_i   (clk_i),
    .mr_i    (mr_i),
    .en_q    (en_q),
    .half_o  (half_o),
    .ratio_o (ratio_o),
    .mark_o  (mark_o)
);

// File: tb/dual_ratio_clkdiv_tb_top.sv
module dual_ratio_clkdiv_tb_top;

    logic clk = 1'b0;
    logic mr  = 1'b1;
    logic en  = 1'b0;
    logic sel = 1'b0;
    logic half_w, ratio_w, mark_w;

    int n_chk  = 0;
    int n_fail = 0;

    // reference state
    logic en_seen;
    logic m2, m46, mmk;
    int   mpos, mn;

    always #5 clk = ~clk;

    dual_ratio_clkdiv dut_i (
        .clk_i       (clk),
        .mr_i        (mr),
        .en_i        (en),
        .ratio_sel_i (sel),
        .half_o      (half_w),
        .ratio_o     (ratio_w),
        .mark_o      (mark_w)
    );

    // R7: enable seen by the bench only at falling edges
    always @(negedge clk or posedge mr) begin
        if (mr) en_seen <= 1'b0;
        else    en_seen <= en;
    end

    task automatic model_reset();
        m2 = 0; m46 = 0; mmk = 0; mpos = 0; mn = 4;
    endtask

    task automatic model_edge();
        int n;
        if (en_seen) begin
            m2 = ~m2;
            n  = (mpos == 0) ? (sel ? 6 : 4) : mn;
            mn = n;
            mpos = (mpos == n - 1) ? 0 : mpos + 1;
            m46 = (mpos >= 1) && (mpos <= n / 2);
            mmk = m2 && (mpos == 1);
        end else begin
            mmk = 0;
        end
    endtask

    task automatic check(input string tag, input logic a2, input logic a46,
                         input logic amk, input logic e2, input logic e46,
                         input logic emk);
        n_chk++;
        if ({a2, a46, amk} !== {e2, e46, emk}) begin
            n_fail++;
            $display("FAIL %s: half/ratio/mark actual %b%b%b expected %b%b%b at %0t",
                     tag, a2, a46, amk, e2, e46, emk, $time);
        end
    endtask

    // one cycle: update model at edge, drive, sample mid-high phase
    task automatic step(input logic e, input logic s, input bit late, input string tag);
        @(posedge clk);
        if (!mr) model_edge();
        if (!late) begin
            #1; en = e; sel = s;
            #2;
            check(tag, half_w, ratio_w, mark_w, m2, m46, mmk);
        end else begin
            #3;
            check(tag, half_w, ratio_w, mark_w, m2, m46, mmk);
            #4; en = e; sel = s;
        end
    endtask

    task automatic do_reset();
        mr = 1'b1;
        model_reset();
        repeat (2) @(posedge clk);
        #2;
        check("R1 in reset", half_w, ratio_w, mark_w, 1'b0, 1'b0, 1'b0);
        mr = 1'b0;
    endtask

    task automatic t_reset();
        en = 1'b0; sel = 1'b0;
        do_reset();
        step(1'b0, 1'b0, 0, "R1 after release");
        step(1'b0, 1'b0, 0, "R1 idle");
    endtask

    task automatic t_div4();
        int rises = 0;
        do_reset();
        step(1'b1, 1'b0, 0, "R3 start");
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, 0, "R3 div4");
            if (i == 0) check("R5 first rise", half_w, ratio_w, mark_w, 1'b1, 1'b1, 1'b1);
            if (mark_w) rises++;
        end
        n_chk++;
        if (rises != 5) begin
            n_fail++;
            $display("FAIL R6 mark count actual %0d expected 5", rises);
        end
    endtask

    task automatic t_div6();
        do_reset();
        step(1'b1, 1'b1, 0, "R4 start");
        for (int i = 0; i < 24; i++) step(1'b1, 1'b1, 0, "R4 div6");
    endtask

    task automatic t_freeze();
        do_reset();
        step(1'b1, 1'b1, 0, "R8 run");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 0, "R8 run");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 0, "R8 frozen");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 0, "R8 resume");
        for (int i = 0; i < 3; i++) step(i[0], 1'b0, 0, "R8 toggle");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 0, "R8 resume4");
    endtask

    task automatic t_late_enable();
        do_reset();
        step(1'b1, 1'b0, 0, "R7 run");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, "R7 run");
        step(1'b0, 1'b0, 1, "R7 late off");
        step(1'b0, 1'b0, 0, "R7 still on");
        step(1'b0, 1'b0, 0, "R7 off");
        step(1'b1, 1'b0, 1, "R7 late on");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, "R7 on");
    endtask

    task automatic t_select();
        do_reset();
        step(1'b1, 1'b0, 0, "R9 div4");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, "R9 div4");
        step(1'b1, 1'b1, 0, "R9 switch mid");
        for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 0, "R9 div6");
        step(1'b1, 1'b0, 0, "R9 back");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 0, "R9 div4 again");
    endtask

    task automatic t_async_reset();
        do_reset();
        step(1'b1, 1'b1, 0, "R10 run");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 0, "R10 run");
        @(posedge clk);
        #2; mr = 1'b1; model_reset();
        #1;
        check("R10 immediate clear", half_w, ratio_w, mark_w, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        #3; mr = 1'b0;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 0, "R10 restart");
    endtask

    initial begin
        model_reset();
        t_reset();
        t_div4();
        t_div6();
        t_freeze();
        t_late_enable();
        t_select();
        t_async_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule